// File: doc/BRIEF.md
# Packed Monochrome Frame Buffer

This block stores a one-bit-per-pixel image for a raster display. The memory packs eight horizontally adjacent pixels into each byte. The block has two independent ports. A byte-wide read/write port serves a drawing engine. Because pixels share bytes, that engine sets or clears a single pixel by reading the byte, changing one bit and writing the byte back. A read-only display port takes the raster coordinates and the active-video flag from an external timing generator. It turns the coordinates into a byte address, picks out the addressed bit and drives a white or black pixel on three colour channels.

The screen size is set by parameters. A production build sets 1280 by 1024 pixels, which gives 163840 bytes. The defaults are kept small so that the block elaborates quickly. Sync generation and clock synthesis belong to other blocks. The memory is written behaviourally.

Top module: `mono_fb`

## Requirements
- R1: While reset is asserted, and until the first display sample after reset is released, all colour outputs are zero.
- R2: A pixel (x, y) has the linear index y*W + x. It is stored in byte index>>3, at bit (index & 7), where bit 0 is the leftmost pixel of the byte. Rows are packed back to back, so a byte can span the end of one row and the start of the next.
- R3: A port-A read (a_en=1, a_we=0) returns the addressed byte on a_rdata one clock after the address is sampled.
- R4: A port-A write (a_en=1, a_we=1) stores a_wdata. In that same access, a_rdata returns the byte's previous content one clock later.
- R5: Display latency is one clock. A stored 1 gives every channel its full value (all CW bits set), and a stored 0 gives zero on every channel.
- R6: When disp_act is low, the pixel output one clock later is black on all channels, whatever the memory holds.
- R7: When disp_act is high but disp_x >= W or disp_y >= H, the pixel output one clock later is black.
- R8: If port A writes a byte in the same cycle that the display port reads it, the display shows the old content. The new content is shown from the next read on.
- R9: While a_en is low, port A neither writes memory nor changes a_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| a_en | input | 1 | Port-A access enable |
| a_we | input | 1 | Port-A write select (1 = write) |
| a_addr | input | AW | Port-A byte address |
| a_wdata | input | 8 | Port-A write byte |
| a_rdata | output | 8 | Port-A read byte (old content on a write) |
| disp_act | input | 1 | Raster is in the visible area |
| disp_x | input | XW | Raster column |
| disp_y | input | YW | Raster row |
| pix_r | output | CW | Red channel |
| pix_g | output | CW | Green channel |
| pix_b | output | CW | Blue channel |

## Verification
The bench builds the block with W=12, H=8, XW=4, YW=4 and CW=4. That gives a 12-byte memory in which bytes straddle row ends, so the packing of R2 is exercised beyond a plain per-row layout. With 4-bit coordinates, every (x, y) from 0 to 15 can be swept. That sweep covers all 96 visible pixels and every out-of-range column and row in one pass. The small memory also lets every byte be written twice and read back, so the read-first behaviour of R4 and the same-byte collision of R8 are checked against computed patterns.

// File: rtl/mfb_pkg.sv
package mfb_pkg;
  // bytes needed for a w-by-h bit image
  function automatic int bytes_for(input int w, input int h);
    return (w * h + 7) / 8;
  endfunction

  // display-side tag carried alongside the memory read
  typedef struct packed {
    logic       act;
    logic       inr;
    logic [2:0] bsel;
  } pix_tag_t;
endpackage

// File: rtl/mfb_rst_sync.sv
module mfb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic s1_q, s2_q;
  logic s1_d, s2_d;

  always_comb begin
    s1_d = 1'b1;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign rst_q_n = s2_q;
endmodule

// File: rtl/mfb_addr_map.sv
module mfb_addr_map #(
  parameter int W  = 64,
  parameter int H  = 32,
  parameter int XW = 7,
  parameter int YW = 6,
  parameter int AW = 8
) (
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  output logic [AW-1:0] baddr,
  output logic [2:0]    bsel,
  output logic          in_range
);
  localparam int IW = AW + 3;

  logic [IW-1:0] idx;
  logic          x_ok, y_ok;

  always_comb begin
    x_ok     = (32'(x) < W);
    y_ok     = (32'(y) < H);
    in_range = x_ok && y_ok;
    idx      = IW'(y) * IW'(W) + IW'(x);
    if (in_range) begin
      baddr = idx[IW-1:3];
      bsel  = idx[2:0];
    end else begin
      baddr = '0;
      bsel  = '0;
    end
  end
endmodule

// File: rtl/mfb_dpram.sv
module mfb_dpram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [7:0]    b_rdata
);
  logic [7:0] mem [DEPTH];

  // drawing port: read-first, enable-gated
  always_ff @(posedge clk) begin
    if (a_en) begin
      a_rdata <= mem[a_addr];
      if (a_we) begin
        mem[a_addr] <= a_wdata;
      end
    end
  end

  // display port: always reading, sees old data on same-cycle write
  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/mfb_pix_out.sv
module mfb_pix_out #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic          inr,
  input  logic [2:0]    bsel,
  input  logic [7:0]    bdata,
  output logic [CW-1:0] pix_r,
  output logic [CW-1:0] pix_g,
  output logic [CW-1:0] pix_b
);
  import mfb_pkg::*;

  pix_tag_t tag_d, tag_q;
  logic     lit;

  always_comb begin
    tag_d.act  = act;
    tag_d.inr  = inr;
    tag_d.bsel = bsel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else begin
      tag_q <= tag_d;
    end
  end

  always_comb begin
    lit   = tag_q.act && tag_q.inr && bdata[tag_q.bsel];
    pix_r = {CW{lit}};
    pix_g = {CW{lit}};
    pix_b = {CW{lit}};
  end
endmodule

// File: rtl/mono_fb.sv
module mono_fb #(
  parameter int W  = 64,
  parameter int H  = 32,
  parameter int XW = 7,
  parameter int YW = 6,
  parameter int CW = 8,
  localparam int BYTES = mfb_pkg::bytes_for(W, H),
  localparam int AW    = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic          disp_act,
  input  logic [XW-1:0] disp_x,
  input  logic [YW-1:0] disp_y,
  output logic [CW-1:0] pix_r,
  output logic [CW-1:0] pix_g,
  output logic [CW-1:0] pix_b
);
  logic          rst_q_n;
  logic [AW-1:0] b_addr;
  logic [2:0]    b_bsel;
  logic          b_inr;
  logic [7:0]    b_rdata;

  mfb_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  mfb_addr_map #(.W(W), .H(H), .XW(XW), .YW(YW), .AW(AW)) u_map (
    .x        (disp_x),
    .y        (disp_y),
    .baddr    (b_addr),
    .bsel     (b_bsel),
    .in_range (b_inr)
  );

  mfb_dpram #(.DEPTH(BYTES), .AW(AW)) u_mem (
    .clk     (clk),
    .a_en    (a_en),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .a_rdata (a_rdata),
    .b_addr  (b_addr),
    .b_rdata (b_rdata)
  );

  mfb_pix_out #(.CW(CW)) u_pix (
    .clk   (clk),
    .rst_n (rst_q_n),
    .act   (disp_act),
    .inr   (b_inr),
    .bsel  (b_bsel),
    .bdata (b_rdata),
    .pix_r (pix_r),
    .pix_g (pix_g),
    .pix_b (pix_b)
  );
endmodule

// File: rtl/mono_fb_chk.sv
module mono_fb_chk #(
  parameter int W  = 64,
  parameter int H  = 32,
  parameter int XW = 7,
  parameter int YW = 6,
  parameter int CW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_en,
  input logic          a_we,
  input logic [AW-1:0] a_addr,
  input logic [7:0]    a_wdata,
  input logic [7:0]    a_rdata,
  input logic          disp_act,
  input logic [XW-1:0] disp_x,
  input logic [YW-1:0] disp_y,
  input logic [CW-1:0] pix_r,
  input logic [CW-1:0] pix_g,
  input logic [CW-1:0] pix_b
);
  logic black;
  assign black = (pix_r == '0) && (pix_g == '0) && (pix_b == '0);

  AST_MONO_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_r == pix_g) && (pix_g == pix_b) && ((pix_r == '0) || (pix_r == '1))); // R5

  AST_BLACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!disp_act) |-> black); // R6

  AST_BLACK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(disp_act && ((32'(disp_x) >= W) || (32'(disp_y) >= H))) |-> black); // R7

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(a_en && a_we, 2) && $past(a_en && !a_we) && ($past(a_addr) == $past(a_addr, 2)))
      |-> (a_rdata == $past(a_wdata, 2))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!a_en) |-> $stable(a_rdata)); // R9
endmodule

bind mono_fb mono_fb_chk #(.W(W), .H(H), .XW(XW), .YW(YW), .CW(CW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .a_en     (a_en),
  .a_we     (a_we),
  .a_addr   (a_addr),
  .a_wdata  (a_wdata),
  .a_rdata  (a_rdata),
  .disp_act (disp_act),
  .disp_x   (disp_x),
  .disp_y   (disp_y),
  .pix_r    (pix_r),
  .pix_g    (pix_g),
  .pix_b    (pix_b)
);

// File: tb/sim_mono_fb.sv
module sim_mono_fb;
  localparam int W = 12, H = 8, XW = 4, YW = 4, CW = 4;
  localparam int BYTES = (W * H + 7) / 8;
  localparam int AW = $clog2(BYTES);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_en = 1'b0, a_we = 1'b0;
  logic [AW-1:0] a_addr = '0;
  logic [7:0]    a_wdata = '0;
  logic [7:0]    a_rdata;
  logic          disp_act = 1'b0;
  logic [XW-1:0] disp_x = '0;
  logic [YW-1:0] disp_y = '0;
  logic [CW-1:0] pix_r, pix_g, pix_b;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mono_fb #(.W(W), .H(H), .XW(XW), .YW(YW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .disp_act(disp_act),
    .disp_x(disp_x), .disp_y(disp_y), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b));

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 53 + 29) & 255);
  endfunction

  function automatic logic exp_bit(input int x, input int y, input logic [7:0] b [BYTES]);
    int idx;
    if (x >= W || y >= H) return 1'b0;
    idx = y * W + x;
    return b[idx >> 3][idx & 7];
  endfunction

  logic [7:0] model [BYTES];

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkpix(input string req, input logic lit);
    logic [3*CW-1:0] a, e;
    a = {pix_r, pix_g, pix_b};
    e = {3*CW{lit}};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic go_neg;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs black even with display requested
    disp_act = 1'b1;
    repeat (3) step();
    chkpix("R1 during reset", 1'b0);
    go_neg(); rst_n = 1'b1; disp_act = 1'b0;
    repeat (3) step();
    chkpix("R1 after release", 1'b0);

    // fill with inverse pattern, then overwrite with pattern; R4 read-first
    for (int a = 0; a < BYTES; a++) begin
      go_neg(); a_en = 1; a_we = 1; a_addr = AW'(a); a_wdata = ~pat(a);
    end
    for (int a = 0; a < BYTES; a++) begin
      go_neg(); a_en = 1; a_we = 1; a_addr = AW'(a); a_wdata = pat(a);
      step();
      chk8("R4 old data on write", a_rdata, ~pat(a));
      model[a] = pat(a);
    end
    // R3 readback
    for (int a = 0; a < BYTES; a++) begin
      go_neg(); a_en = 1; a_we = 0; a_addr = AW'(a);
      step();
      chk8("R3 read latency", a_rdata, pat(a));
    end
    // R9: disabled port neither writes nor changes rdata
    go_neg(); a_en = 0; a_we = 1; a_addr = '0; a_wdata = 8'h00;
    step(); step();
    chk8("R9 rdata held", a_rdata, pat(BYTES - 1));
    go_neg(); a_en = 1; a_we = 0; a_addr = '0;
    step();
    chk8("R9 no write", a_rdata, pat(0));
    go_neg(); a_en = 0;

    // R2 R5 R7: full coordinate sweep, visible and beyond
    for (int y = 0; y < 16; y++) begin
      for (int x = 0; x < 16; x++) begin
        go_neg(); disp_act = 1; disp_x = XW'(x); disp_y = YW'(y);
        step();
        chkpix((x >= W || y >= H) ? "R7 out of range" : "R2 R5 mapping", exp_bit(x, y, model));
      end
    end
    // R6: inactive raster blanks even lit pixels
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        go_neg(); disp_act = 0; disp_x = XW'(x); disp_y = YW'(y);
        step();
        chkpix("R6 blank when inactive", 1'b0);
      end
    end

    // R8: same-byte collision, pixel (3,1) -> index 15 -> byte 1 bit 7
    go_neg(); disp_act = 1; disp_x = 3; disp_y = 1;
    a_en = 1; a_we = 1; a_addr = 1; a_wdata = ~pat(1);
    step();
    chkpix("R8 old data shown", pat(1)[7]);
    chk8("R4 collision rdata", a_rdata, pat(1));
    model[1] = ~pat(1);
    go_neg(); a_en = 0; a_we = 0;
    step();
    chkpix("R8 new data next", model[1][7]);

    go_neg(); disp_act = 0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule